// File: doc/BRIEF.md
# Host Register File for a Successive-Approximation Converter

This block gives a host an 8-bit register window over eight consecutive byte addresses and uses it to run an external 12-bit successive-approximation converter. A host write to one of the two data addresses requests a conversion. Which of the two addresses is written picks a short 8-bit conversion or a full 12-bit one. The block turns the request into a one-cycle start pulse for the converter. When the converter's busy line falls, the block captures the 12-bit result and holds it. The host then reads the result back as two bytes.

A shared status/control address has different meanings for reads and writes. A write loads four general-purpose output lines, an interrupt enable and the 3-bit channel select of the input multiplexer. A read returns the busy flag, three sampled input lines, the state of an edge-triggered interrupt latch and the current channel. The upper four addresses belong to a neighbouring counter block. For those addresses the block only decodes strobes and passes the neighbour's read data through. The block also keeps a saturating count of conversion requests that it rejected because a conversion was already in progress. This count is brought out for test.

Top module: `adc_regfile`

## Requirements
- R1: After reset the channel select, output lines, interrupt enable, start pulse, long-mode flag, dropped-request count, interrupt latch and held result are all zero.
- R2: A write of any value to offset 0 or offset 1 while the block is idle makes `conv_start` high for exactly one cycle, starting with the cycle after the write edge. `conv_long` is 0 for offset 0 and 1 for offset 1.
- R3: The block is busy while `conv_busy` is high or while a start pulse is in flight. A write to offset 0 or 1 while busy produces no start pulse and adds one to `drop_count`, which saturates at its all-ones value.
- R4: The result register takes `conv_result` at the first clock edge at which `conv_busy` is seen low after being high. At every other edge it keeps its value.
- R5: A read of offset 1 returns result bits 11..4. A read of offset 0 returns result bits 3..0 in data bits 7..4, with data bits 3..0 equal to zero. The code is offset binary: 0x000 is negative full scale, 0x800 is mid-scale and 0xFFF is positive full scale.
- R6: A read of offset 2 returns the status byte. Bit 7 is the busy flag of R3. Bits 6..4 are the input lines `din[2:0]`, sampled by one register. Bit 3 is the interrupt latch. Bits 2..0 are the current channel.
- R7: A write to offset 2 sets `dout` from data bits 7..4, `irq_en` from bit 3 and `mux_sel` from bits 2..0. It also clears the interrupt latch.
- R8: A rising edge on `irq_req` sets the interrupt latch two clock edges after the input rises. If the set and a clearing write land on the same edge, the set wins. `irq_out` is the latch gated by `irq_en`.
- R9: Offset 3 is unused: writes to it change no register and start nothing, and reads of offset 3 or offset 7 return zero.
- R10: In the same cycle as the access, a write to offset 4, 5 or 6 raises bit 0, 1 or 2 of `cnt_wr_stb`, and a write to offset 7 raises `cnt_ctl_stb`. A read of offset 4, 5 or 6 raises the matching bit of `cnt_rd_stb` and returns `cnt_rdata`.
- R11: `rdata` is zero whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data (combinational) |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_long | output | 1 | 1 selects a 12-bit conversion, 0 an 8-bit one |
| conv_busy | input | 1 | Converter busy |
| conv_result | input | 12 | Converter output code |
| mux_sel | output | 3 | Input multiplexer channel |
| dout | output | 4 | General-purpose output lines |
| irq_en | output | 1 | Interrupt enable |
| din | input | 3 | General-purpose input lines |
| irq_req | input | 1 | Interrupt/trigger request input |
| irq_out | output | 1 | Gated interrupt request |
| cnt_wr_stb | output | 3 | Write strobes for counter data windows 0..2 |
| cnt_rd_stb | output | 3 | Read strobes for counter data windows 0..2 |
| cnt_ctl_stb | output | 1 | Write strobe for the counter control byte |
| cnt_rdata | input | 8 | Read data from the counter block |
| drop_count | output | 8 | Saturating count of rejected conversion requests |

## Verification
The bench targets requests that arrive while a start pulse is still in flight but before the converter has raised busy. A design that used only `conv_busy` to decide would issue a second start pulse there. It checks the result bytes at the code extremes and at mid-scale, and it changes `conv_result` both during and after a conversion. A design that captured on the wrong edge, or that placed the low nibble right-justified, would then return visibly wrong bytes. It makes an interrupt edge and a clearing status write land on the same clock edge, so a design that gave the clear priority would lose the interrupt. It also drives 260 rejected requests to expose a dropped-request counter that wraps instead of saturating.

// File: rtl/adc_rf_pkg.sv
package adc_rf_pkg;
  localparam int BYTE_W = 8;
  localparam int RES_W  = 12;
  localparam int LO_W   = RES_W - BYTE_W;
  localparam int CH_W   = 3;
  localparam int DOUT_W = 4;
  localparam int DIN_W  = 3;
  localparam int ADDR_W = 3;
  localparam int NUM_CNT = 3;

  localparam logic [ADDR_W-1:0] OFS_CONV_LO = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_CONV_HI = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_STAT    = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_SPARE   = 3'd3;
  localparam int                OFS_CNT0    = 4;
  localparam logic [ADDR_W-1:0] OFS_CNT_CTL = 3'd7;

  typedef struct packed {
    logic [DOUT_W-1:0] dout;
    logic              irq_en;
    logic [CH_W-1:0]   mux;
  } ctrl_t;

  typedef struct packed {
    logic             busy;
    logic [DIN_W-1:0] din;
    logic             latch;
    logic [CH_W-1:0]  mux;
  } stat_t;

  function automatic logic [BYTE_W-1:0] res_hi_byte(input logic [RES_W-1:0] r);
    return r[RES_W-1 -: BYTE_W];
  endfunction

  function automatic logic [BYTE_W-1:0] res_lo_byte(input logic [RES_W-1:0] r);
    return {r[LO_W-1:0], {(BYTE_W-LO_W){1'b0}}};
  endfunction

  function automatic logic [BYTE_W-1:0] pack_status(input stat_t s);
    return BYTE_W'(s);
  endfunction
endpackage

// File: rtl/adc_rf_decode.sv
module adc_rf_decode
  import adc_rf_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic               rd_en,
  output logic               req_short,
  output logic               req_long,
  output logic               ctrl_wr,
  output logic [NUM_CNT-1:0] cnt_wr_stb,
  output logic [NUM_CNT-1:0] cnt_rd_stb,
  output logic               cnt_ctl_stb
);
  assign req_short   = wr_en && (addr == OFS_CONV_LO);
  assign req_long    = wr_en && (addr == OFS_CONV_HI);
  assign ctrl_wr     = wr_en && (addr == OFS_STAT);
  assign cnt_ctl_stb = wr_en && (addr == OFS_CNT_CTL);

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt_win
    localparam logic [ADDR_W-1:0] WIN_OFS = ADDR_W'(OFS_CNT0 + g);
    assign cnt_wr_stb[g] = wr_en && (addr == WIN_OFS);
    assign cnt_rd_stb[g] = rd_en && (addr == WIN_OFS);
  end
endmodule

// File: rtl/adc_rf_conv.sv
module adc_rf_conv
  import adc_rf_pkg::*;
#(
  parameter int DROP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_short,
  input  logic              req_long,
  input  logic              conv_busy,
  input  logic [RES_W-1:0]  conv_result,
  output logic              conv_start,
  output logic              conv_long,
  output logic              busy_flag,
  output logic [RES_W-1:0]  res_q,
  output logic [DROP_W-1:0] drop_count,
  output logic              start_accept,
  output logic              start_drop,
  output logic              busy_fall
);
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  logic start_q, long_q, busy_d;
  logic req_any;

  assign req_any      = req_short | req_long;
  assign busy_flag    = conv_busy | start_q;
  assign start_accept = req_any & ~busy_flag;
  assign start_drop   = req_any & busy_flag;
  assign busy_fall    = busy_d & ~conv_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q    <= 1'b0;
      long_q     <= 1'b0;
      busy_d     <= 1'b0;
      res_q      <= '0;
      drop_count <= '0;
    end else begin
      start_q <= start_accept;
      busy_d  <= conv_busy;
      if (start_accept) long_q <= req_long;
      if (busy_fall) res_q <= conv_result;
      if (start_drop && drop_count != DROP_MAX) drop_count <= drop_count + 1'b1;
    end
  end

  assign conv_start = start_q;
  assign conv_long  = long_q;
endmodule

// File: rtl/adc_rf_ctrl.sv
module adc_rf_ctrl
  import adc_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [DIN_W-1:0]  din,
  input  logic              irq_req,
  output ctrl_t             ctrl_q,
  output logic [DIN_W-1:0]  din_q,
  output logic              irq_latch,
  output logic              irq_rise
);
  logic irq_q, irq_qq;

  assign irq_rise = irq_q & ~irq_qq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      din_q     <= '0;
      irq_q     <= 1'b0;
      irq_qq    <= 1'b0;
      irq_latch <= 1'b0;
    end else begin
      din_q  <= din;
      irq_q  <= irq_req;
      irq_qq <= irq_q;
      if (ctrl_wr) ctrl_q <= ctrl_t'(wdata);
      // a new edge outranks a clearing write on the same cycle
      if (irq_rise)     irq_latch <= 1'b1;
      else if (ctrl_wr) irq_latch <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_regfile.sv
module adc_regfile
  import adc_rf_pkg::*;
#(
  parameter int DROP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [BYTE_W-1:0]  wdata,
  output logic [BYTE_W-1:0]  rdata,
  output logic               conv_start,
  output logic               conv_long,
  input  logic               conv_busy,
  input  logic [RES_W-1:0]   conv_result,
  output logic [CH_W-1:0]    mux_sel,
  output logic [DOUT_W-1:0]  dout,
  output logic               irq_en,
  input  logic [DIN_W-1:0]   din,
  input  logic               irq_req,
  output logic               irq_out,
  output logic [NUM_CNT-1:0] cnt_wr_stb,
  output logic [NUM_CNT-1:0] cnt_rd_stb,
  output logic               cnt_ctl_stb,
  input  logic [BYTE_W-1:0]  cnt_rdata,
  output logic [DROP_W-1:0]  drop_count
);
  logic             req_short, req_long, ctrl_wr;
  logic             busy_flag, start_accept, start_drop, busy_fall;
  logic [RES_W-1:0] res_q;
  ctrl_t            ctrl_q;
  logic [DIN_W-1:0] din_q;
  logic             irq_latch, irq_rise;
  stat_t            stat;

  adc_rf_decode u_decode (
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .req_short(req_short), .req_long(req_long), .ctrl_wr(ctrl_wr),
    .cnt_wr_stb(cnt_wr_stb), .cnt_rd_stb(cnt_rd_stb), .cnt_ctl_stb(cnt_ctl_stb)
  );

  adc_rf_conv #(.DROP_W(DROP_W)) u_conv (
    .clk(clk), .rst_n(rst_n),
    .req_short(req_short), .req_long(req_long),
    .conv_busy(conv_busy), .conv_result(conv_result),
    .conv_start(conv_start), .conv_long(conv_long),
    .busy_flag(busy_flag), .res_q(res_q), .drop_count(drop_count),
    .start_accept(start_accept), .start_drop(start_drop), .busy_fall(busy_fall)
  );

  adc_rf_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wdata(wdata),
    .din(din), .irq_req(irq_req),
    .ctrl_q(ctrl_q), .din_q(din_q), .irq_latch(irq_latch), .irq_rise(irq_rise)
  );

  assign mux_sel = ctrl_q.mux;
  assign dout    = ctrl_q.dout;
  assign irq_en  = ctrl_q.irq_en;
  assign irq_out = irq_latch & ctrl_q.irq_en;

  always_comb begin
    stat.busy  = busy_flag;
    stat.din   = din_q;
    stat.latch = irq_latch;
    stat.mux   = ctrl_q.mux;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFS_CONV_LO: rdata = res_lo_byte(res_q);
        OFS_CONV_HI: rdata = res_hi_byte(res_q);
        OFS_STAT:    rdata = pack_status(stat);
        default:     rdata = (|cnt_rd_stb) ? cnt_rdata : '0;
      endcase
    end
  end
endmodule

// File: rtl/adc_regfile_chk.sv
module adc_regfile_chk
  import adc_rf_pkg::*;
#(
  parameter int DROP_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [BYTE_W-1:0]  wdata,
  input logic               conv_start,
  input logic [CH_W-1:0]    mux_sel,
  input logic               irq_out,
  input logic               irq_en,
  input logic [NUM_CNT-1:0] cnt_wr_stb,
  input logic               cnt_ctl_stb,
  input logic               start_accept,
  input logic               start_drop,
  input logic               busy_fall,
  input logic               ctrl_wr,
  input logic [RES_W-1:0]   res_q,
  input logic [DROP_W-1:0]  drop_count
);
  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |=> conv_start);
  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R3
  drop_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_drop |=> !conv_start);
  // R3
  drop_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> drop_count >= $past(drop_count));
  // R4
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_fall |=> $stable(res_q));
  // R7
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> mux_sel == $past(wdata[CH_W-1:0]));
  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> irq_en);
  // R10
  cnt_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cnt_wr_stb, cnt_ctl_stb}));
endmodule

bind adc_regfile adc_regfile_chk #(.DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wdata(wdata), .conv_start(conv_start),
  .mux_sel(mux_sel), .irq_out(irq_out), .irq_en(irq_en),
  .cnt_wr_stb(cnt_wr_stb), .cnt_ctl_stb(cnt_ctl_stb),
  .start_accept(start_accept), .start_drop(start_drop), .busy_fall(busy_fall),
  .ctrl_wr(ctrl_wr), .res_q(res_q), .drop_count(drop_count)
);

// File: tb/test_adc_regfile.sv
module test_adc_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        conv_start, conv_long;
  logic        conv_busy = 1'b0;
  logic [11:0] conv_result = '0;
  logic [2:0]  mux_sel;
  logic [3:0]  dout;
  logic        irq_en;
  logic [2:0]  din = '0;
  logic        irq_req = 1'b0;
  logic        irq_out;
  logic [2:0]  cnt_wr_stb, cnt_rd_stb;
  logic        cnt_ctl_stb;
  logic [7:0]  cnt_rdata = '0;
  logic [7:0]  drop_count;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  adc_regfile i_adc_regfile (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .conv_start(conv_start), .conv_long(conv_long),
    .conv_busy(conv_busy), .conv_result(conv_result), .mux_sel(mux_sel),
    .dout(dout), .irq_en(irq_en), .din(din), .irq_req(irq_req), .irq_out(irq_out),
    .cnt_wr_stb(cnt_wr_stb), .cnt_rd_stb(cnt_rd_stb), .cnt_ctl_stb(cnt_ctl_stb),
    .cnt_rdata(cnt_rdata), .drop_count(drop_count)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  function automatic logic [7:0] exp_lo(input logic [11:0] r);
    return r[3:0] * 8'd16;
  endfunction

  task automatic t_reset();
    logic [7:0] s;
    chk("R1 mux", mux_sel, 0); chk("R1 dout", dout, 0); chk("R1 irq_en", irq_en, 0);
    chk("R1 start", conv_start, 0); chk("R1 long", conv_long, 0);
    chk("R1 drop", drop_count, 0); chk("R1 irq_out", irq_out, 0);
    do_read(3'd2, s); chk("R1 R6 status", s, 8'h00);
    do_read(3'd1, s); chk("R1 result hi", s, 8'h00);
  endtask

  task automatic t_start();
    do_write(3'd0, 8'h5A);
    chk("R2 short start", conv_start, 1); chk("R2 short mode", conv_long, 0);
    tick(); chk("R2 pulse width", conv_start, 0);
    do_write(3'd1, 8'h00);
    chk("R2 long start", conv_start, 1); chk("R2 long mode", conv_long, 1);
    tick(); chk("R2 pulse width long", conv_start, 0);
  endtask

  task automatic t_drop();
    logic [7:0] s;
    conv_busy = 1'b1; tick();
    do_write(3'd1, 8'hFF);
    chk("R3 no start while busy", conv_start, 0); chk("R3 drop one", drop_count, 1);
    do_read(3'd2, s); chk("R6 busy bit", s[7], 1);
    conv_busy = 1'b0; tick(); tick();
    do_write(3'd0, 8'h00);
    do_write(3'd0, 8'h00);
    chk("R3 in-flight start dropped", conv_start, 0); chk("R3 drop two", drop_count, 2);
  endtask

  task automatic run_conv(input logic [11:0] r);
    conv_busy = 1'b1; conv_result = ~r; tick();
    conv_result = r; conv_busy = 1'b0; tick();
    conv_result = 12'h3C3;
  endtask

  task automatic t_result();
    logic [7:0] h, l;
    logic [11:0] codes [4] = '{12'hA5C, 12'hFFF, 12'h000, 12'h800};
    foreach (codes[i]) begin
      run_conv(codes[i]);
      do_read(3'd1, h); do_read(3'd0, l);
      chk("R5 hi byte", h, codes[i] >> 4);
      chk("R5 lo byte", l, exp_lo(codes[i]));
    end
    conv_result = 12'h7E1; tick(); tick();
    do_read(3'd1, h); chk("R4 hold after done", h, 8'h80);
    conv_busy = 1'b1; tick(); do_read(3'd1, h); chk("R4 hold while busy", h, 8'h80);
    conv_busy = 1'b0; tick(); do_read(3'd1, h); chk("R4 capture on fall", h, 8'h7E);
  endtask

  task automatic t_ctrl();
    logic [7:0] s;
    do_write(3'd2, 8'hB6);
    chk("R7 mux", mux_sel, 6); chk("R7 dout", dout, 4'hB); chk("R7 irq_en", irq_en, 0);
    do_read(3'd2, s); chk("R6 status mux", s, 8'h06);
    din = 3'b101; tick();
    do_write(3'd2, 8'h0D);
    chk("R7 mux 2", mux_sel, 5); chk("R7 dout 2", dout, 0); chk("R7 irq_en 2", irq_en, 1);
    do_read(3'd2, s); chk("R6 status din", s, 8'h55);
    din = 3'b000; tick();
  endtask

  task automatic t_irq();
    logic [7:0] s;
    irq_req = 1'b1; tick(); tick();
    do_read(3'd2, s); chk("R8 latch set", s[3], 1); chk("R8 irq_out", irq_out, 1);
    do_write(3'd2, 8'h08);
    do_read(3'd2, s); chk("R7 latch cleared", s[3], 0); chk("R8 irq_out clear", irq_out, 0);
    irq_req = 1'b0; tick(); tick();
    irq_req = 1'b1; tick();
    do_write(3'd2, 8'h00);
    do_read(3'd2, s); chk("R8 set wins over clear", s[3], 1);
    chk("R8 gated off", irq_out, 0);
    do_write(3'd2, 8'h08);
    chk("R8 cleared enabled", irq_out, 0);
    irq_req = 1'b0; tick();
  endtask

  task automatic t_unused();
    logic [7:0] s;
    do_write(3'd2, 8'h93);
    addr = 3'd3; wdata = 8'hFF; wr_en = 1'b1;
    #1 chk("R9 no counter strobe", {cnt_wr_stb, cnt_ctl_stb}, 0);
    tick(); wr_en = 1'b0;
    chk("R9 mux kept", mux_sel, 3); chk("R9 dout kept", dout, 4'h9);
    chk("R9 irq_en kept", irq_en, 0); chk("R9 no start", conv_start, 0);
    chk("R9 drop kept", drop_count, 2);
    do_read(3'd3, s); chk("R9 read 3", s, 0);
    cnt_rdata = 8'hEE;
    do_read(3'd7, s); chk("R9 read 7", s, 0);
    addr = 3'd1; rd_en = 1'b0;
    #1 chk("R11 idle rdata", rdata, 0);
  endtask

  task automatic t_cnt();
    logic [7:0] s;
    for (int w = 0; w < 3; w++) begin
      addr = 3'(4 + w); wr_en = 1'b1; wdata = 8'h11;
      #1 chk("R10 wr strobe", cnt_wr_stb, 3'b001 << w);
      chk("R10 ctl idle", cnt_ctl_stb, 0);
      tick(); wr_en = 1'b0;
    end
    addr = 3'd7; wr_en = 1'b1;
    #1 chk("R10 ctl strobe", cnt_ctl_stb, 1); chk("R10 wr idle", cnt_wr_stb, 0);
    tick(); wr_en = 1'b0;
    cnt_rdata = 8'h5A;
    addr = 3'd6; rd_en = 1'b1;
    #1 chk("R10 rd strobe", cnt_rd_stb, 3'b100); s = rdata;
    rd_en = 1'b0;
    chk("R10 rd data", s, 8'h5A);
  endtask

  task automatic t_saturate();
    conv_busy = 1'b1; tick();
    for (int k = 0; k < 260; k++) do_write(3'd0, 8'h00);
    chk("R3 saturate", drop_count, 8'hFF);
    chk("R3 no start saturated", conv_start, 0);
    conv_busy = 1'b0; tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_start();
    t_drop();
    t_result();
    t_ctrl();
    t_irq();
    t_unused();
    t_cnt();
    t_saturate();
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule